// File: doc/BRIEF.md
# SPI Master with Programmable Lead and Trail Gaps

This block is a single-word SPI master sequencer. Each accepted command sends one 8-bit word and receives one. The block also places two timing gaps around the transfer. The lead gap runs from chip-select assertion to the first serial clock edge. The trail gap runs from chip-select negation until the block can take the next command. Each command has its own enable bit for each gap. The gap lengths come from a shared lead count and a shared trail count, and a baud divisor sets the serial clock rate.

A controller offers a command with `cmd_valid` and the block takes it in a cycle where `cmd_ready` is high. The gap lengths, the divisor and the data word are all captured when the command is accepted, so the inputs may change afterwards. When the trail gap ends, the block raises `done` for one cycle and presents the received byte on `rx_data`. Serial mode: the clock idles low, data goes out MSB first, MOSI changes on the falling edge, and MISO is sampled on the rising edge.

Top module: `spi_gap_master`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `busy` is 0, `done` is 0 and `cmd_ready` is 1.
- R2: A command is taken only on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only when the block is idle, which means after the previous trail gap has fully elapsed. A `cmd_valid` raised during a transfer or its gaps has no effect on that transfer and starts no extra transfer.
- R3: When `cmd_lead_en` is 1 and `lead_cnt` is nonzero (valid range 1..127), the first rising edge of `spi_sck` comes exactly `lead_cnt` clock cycles after `spi_cs_n` falls.
- R4: When `cmd_lead_en` is 0 or `lead_cnt` is 0, the lead gap is half a serial clock period, which is the effective divisor in clock cycles.
- R5: The serial clock period is 2 × effective divisor clock cycles, with each half lasting one effective divisor. The effective divisor is `baud_div`, except that values 0 and 1 are treated as 2.
- R6: Each transfer is 8 bits, MSB first. The clock idles low. `spi_mosi` changes only on falling edges of `spi_sck` and holds while `spi_sck` is high. `spi_miso` is sampled on rising edges, and the received bits are assembled MSB first into `rx_data`.
- R7: `spi_cs_n` rises one effective divisor of clock cycles after the eighth falling edge of `spi_sck`. `spi_sck` is high only while `spi_cs_n` is low.
- R8: When `cmd_trail_en` is 1, `done` comes 32 × `trail_cnt` cycles after `spi_cs_n` rises (`trail_cnt` valid range 1..255). A `trail_cnt` of 0 gives 8192 cycles.
- R9: When `cmd_trail_en` is 0, `done` comes 17 cycles after `spi_cs_n` rises, whatever the value of `trail_cnt`.
- R10: `busy` stays 1 throughout the trail gap. `done` is a single-cycle pulse, and `busy` is 0 in that cycle. `rx_data` holds the received byte from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block is idle and will take a command |
| cmd_data | input | 8 | Word to transmit |
| cmd_lead_en | input | 1 | Use programmed lead gap for this command |
| cmd_trail_en | input | 1 | Use programmed trail gap for this command |
| lead_cnt | input | 7 | Lead gap in clock cycles |
| trail_cnt | input | 8 | Trail gap in units of 32 clock cycles |
| baud_div | input | 8 | Half serial clock period in clock cycles |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| busy | output | 1 | Transfer or gap in progress |
| done | output | 1 | One-cycle pulse at end of trail gap |
| rx_data | output | 8 | Last received byte |

## Verification
The assertions assume that `spi_miso` is synchronous to `clk` and that the command inputs are valid whenever `cmd_valid` is high. They do not assume that the configuration inputs are held steady, because the block captures them on acceptance. The stimulus drives every input on the falling clock edge. The bench's slave model changes `spi_miso` only after it sees a falling edge of `spi_sck`. Random trail counts are kept small so that many transfers fit in the run. The extreme cases are covered by directed transfers: the 8192-cycle gap, the largest trail count, and divisors 0, 1 and 255.

// File: rtl/spi_gap_master.sv
module spi_gap_master #(
  parameter int WORD_W    = 8,
  parameter int LEAD_W    = 7,
  parameter int GAP_W     = 8,
  parameter int DIV_W     = 8,
  parameter int GAP_SCALE = 32,
  parameter int GAP_ZERO  = 8192,
  parameter int GAP_STD   = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic              cmd_lead_en,
  input  logic              cmd_trail_en,
  input  logic [LEAD_W-1:0] lead_cnt,
  input  logic [GAP_W-1:0]  trail_cnt,
  input  logic [DIV_W-1:0]  baud_div,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_data
);
  localparam int CW = $clog2(GAP_ZERO) + 1;
  localparam int BW = $clog2(WORD_W + 1);

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_SHIFT, S_TAIL, S_GAP} st_t;

  st_t              st;
  logic [CW-1:0]    cnt, gap_m1;
  logic [DIV_W-1:0] div_r;
  logic [WORD_W-1:0] txsh, rxsh;
  logic [BW-1:0]    bits;

  wire [DIV_W-1:0] div_in  = (baud_div < DIV_W'(2)) ? DIV_W'(2) : baud_div;
  wire [CW-1:0]    lead_in = (cmd_lead_en && lead_cnt != '0) ? CW'(lead_cnt) : CW'(div_in);
  wire [CW-1:0]    gap_in  = !cmd_trail_en     ? CW'(GAP_STD) :
                             (trail_cnt == '0) ? CW'(GAP_ZERO) :
                             CW'(trail_cnt) * CW'(GAP_SCALE);
  wire [CW-1:0]    half_m1 = CW'(div_r) - CW'(1);

  assign cmd_ready = (st == S_IDLE);
  assign busy      = !cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      gap_m1   <= '0;
      div_r    <= DIV_W'(2);
      txsh     <= '0;
      rxsh     <= '0;
      bits     <= '0;
      spi_cs_n <= 1'b1;
      spi_sck  <= 1'b0;
      spi_mosi <= 1'b0;
      done     <= 1'b0;
      rx_data  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          st       <= S_LEAD;
          cnt      <= lead_in - CW'(1);
          gap_m1   <= gap_in - CW'(1);
          div_r    <= div_in;
          spi_cs_n <= 1'b0;
          spi_mosi <= cmd_data[WORD_W-1];
          txsh     <= cmd_data << 1;
          bits     <= '0;
        end
        S_LEAD: if (cnt == '0) begin
          st      <= S_SHIFT;
          spi_sck <= 1'b1;
          rxsh    <= {rxsh[WORD_W-2:0], spi_miso};
          bits    <= BW'(1);
          cnt     <= half_m1;
        end else cnt <= cnt - CW'(1);
        S_SHIFT: if (cnt == '0) begin
          cnt <= half_m1;
          if (!spi_sck) begin
            spi_sck <= 1'b1;
            rxsh    <= {rxsh[WORD_W-2:0], spi_miso};
            bits    <= bits + BW'(1);
          end else begin
            spi_sck <= 1'b0;
            if (bits == BW'(WORD_W)) st <= S_TAIL;
            else begin
              spi_mosi <= txsh[WORD_W-1];
              txsh     <= txsh << 1;
            end
          end
        end else cnt <= cnt - CW'(1);
        S_TAIL: if (cnt == '0) begin
          spi_cs_n <= 1'b1;
          st       <= S_GAP;
          cnt      <= gap_m1;
        end else cnt <= cnt - CW'(1);
        S_GAP: if (cnt == '0) begin
          st      <= S_IDLE;
          done    <= 1'b1;
          rx_data <= rxsh;
        end else cnt <= cnt - CW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7
  sck_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> !spi_cs_n);

  // R2
  frame_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && spi_cs_n));

  // R6
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  // R5
  min_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |=> spi_sck);

  // R2
  no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && spi_cs_n) |=> spi_cs_n);
endmodule

// File: tb/spi_gap_master_tb.sv
`timescale 1ns/1ps
module spi_gap_master_tb_top;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_lead_en = 0, cmd_trail_en = 0, spi_miso = 0;
  logic [7:0] cmd_data = 0, trail_cnt = 0, baud_div = 0;
  logic [6:0] lead_cnt = 0;
  logic cmd_ready, spi_cs_n, spi_sck, spi_mosi, busy, done;
  logic [7:0] rx_data;

  always #2 clk = ~clk;

  spi_gap_master dut_i (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .cmd_lead_en(cmd_lead_en), .cmd_trail_en(cmd_trail_en),
    .lead_cnt(lead_cnt), .trail_cnt(trail_cnt), .baud_div(baud_div), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .busy(busy), .done(done),
    .rx_data(rx_data));

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  int t_csf, t_csr, t_first, t_prise, t_fall, t_done, nrise, per_bad, csf_n, gap_busy, sidx, edv;
  logic [7:0] sb, mbits;
  logic p_cs = 1, p_sck = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (p_cs && !spi_cs_n) begin t_csf = cyc; csf_n++; spi_miso = sb[7]; sidx = 6; end
    if (!p_cs && spi_cs_n) t_csr = cyc;
    if (!p_sck && spi_sck) begin
      if (nrise == 0) t_first = cyc;
      else if (cyc - t_prise != 2 * edv) per_bad++;
      t_prise = cyc; nrise++; mbits = {mbits[6:0], spi_mosi};
    end
    if (p_sck && !spi_sck) begin
      t_fall = cyc;
      if (sidx >= 0) begin spi_miso = sb[sidx]; sidx--; end
    end
    if (busy && spi_cs_n && nrise == 8) gap_busy++;
    if (done) t_done = cyc;
    p_cs = spi_cs_n; p_sck = spi_sck;
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int f_div(int dv); return (dv < 2) ? 2 : dv; endfunction
  function automatic int f_lead(bit le, int lc, int dv);
    return (le && lc != 0) ? lc : f_div(dv);
  endfunction
  function automatic int f_gap(bit te, int tc);
    if (!te) return 17;
    return (tc == 0) ? 8192 : 32 * tc;
  endfunction

  task automatic xfer(logic [7:0] d, logic [7:0] s, bit le, int lc, bit te, int tc, int dv, bit poke);
    @(negedge clk);
    cmd_data = d; cmd_lead_en = le; lead_cnt = 7'(lc); cmd_trail_en = te;
    trail_cnt = 8'(tc); baud_div = 8'(dv);
    sb = s; edv = f_div(dv); nrise = 0; per_bad = 0; csf_n = 0; gap_busy = 0; mbits = 0; sidx = -1;
    t_done = -1;
    cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    cmd_data = ~d; lead_cnt = 7'(lc + 3); trail_cnt = 8'(tc + 1); baud_div = 8'(dv + 1);
    if (poke) begin
      while (nrise == 0) @(negedge clk);
      cmd_valid = 1;
      while (!spi_cs_n) @(negedge clk);
      cmd_valid = 0;
    end
    while (t_done < 0) @(negedge clk);
    chk(le && lc != 0 ? "R3 lead" : "R4 lead fallback", t_first - t_csf, f_lead(le, lc, dv));
    chk("R5 sck period errors", per_bad, 0);
    chk("R6 rise count", nrise, 8);
    chk("R6 mosi word", mbits, d);
    chk("R6 rx word", rx_data, s);
    chk("R7 cs tail", t_csr - t_fall, edv);
    chk(te ? "R8 trail gap" : "R9 std gap", t_done - t_csr, f_gap(te, tc));
    chk("R10 busy in gap", gap_busy, f_gap(te, tc));
    if (poke) chk("R2 single frame", csf_n, 1);
    @(negedge clk);
    chk("R10 done one cycle", done, 0);
  endtask

  initial begin
    int seed = 32'h1d5;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R1 cs_n", spi_cs_n, 1);
    chk("R1 sck", spi_sck, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 ready", cmd_ready, 1);
    rst_n = 1;
    xfer(8'hA5, 8'h3C, 1, 5, 0, 9, 3, 0);
    xfer(8'h81, 8'h7E, 1, 0, 0, 0, 4, 0);
    xfer(8'h0F, 8'hF0, 0, 9, 1, 2, 6, 0);
    xfer(8'hFF, 8'h00, 1, 1, 1, 1, 0, 0);
    xfer(8'h00, 8'hFF, 0, 0, 0, 100, 1, 0);
    xfer(8'h5A, 8'hC3, 1, 127, 1, 3, 2, 0);
    xfer(8'h96, 8'h69, 0, 0, 0, 0, 255, 0);
    xfer(8'h33, 8'hCC, 1, 7, 1, 0, 2, 0);
    xfer(8'hE1, 8'h1E, 1, 4, 1, 255, 2, 0);
    xfer(8'hB7, 8'h4D, 1, 2, 0, 0, 3, 1);
    for (int i = 0; i < 30; i++) begin
      xfer(8'($urandom), 8'($urandom), 1'($urandom), int'($urandom % 128), 1'($urandom),
           int'(1 + $urandom % 30), int'($urandom % 16), 1'($urandom % 4 == 0));
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    while (cyc < 190000) @(negedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule